// File: doc/BRIEF.md
# Dual/Single Address DMA Channel

This block is one DMA channel that copies 16-bit words over an external bus with 24-bit addresses. Software-side logic loads a mode, a direction, two addresses with their step enables and a word count, then pulses start. In dual address mode each word costs two bus cycles. The first reads from the source address and the second writes the captured word to the destination address. These cycles run back to back until the count is exhausted.

In single address mode each word costs one bus cycle. Only the memory address goes on the bus. The peripheral on the other side is selected by the acknowledge output, which rises and falls with the address strobe. A direction bit fixes the memory access for the whole job. A memory read sends data towards the device, and the acknowledge then acts as the device's write strobe. A memory write takes data from the device, and the acknowledge then acts as the device's read strobe. In that case the channel keeps its data output disabled.

The device request works like a valid signal, and the acknowledge is the channel accepting it. The channel waits for as long as the request stays low and applies back-pressure to nobody. The request is only looked at between single address cycles. Memory addresses at or above the parameter `INT_BASE` are on-chip, and a single address job aimed there is refused.

Top module: `dma_addr_chan`

## Requirements
- R1: During and right after reset, `busy`, `done`, `err`, `bus_as`, `bus_rd`, `bus_wr`, `bus_doe` and `dack` are all 0.
- R2: A start pulse while idle with a nonzero count makes `busy` 1 in the next cycle. A start with a count of 0 is ignored, so `busy` and the bus strobes stay 0.
- R3: In dual mode (`cfg_mode`=0) each word takes four clocks, with `bus_as` high in all four. In clocks 1 and 2 the source address is on the bus, with `bus_rd` high in clock 2 only. In clocks 3 and 4 the destination address is on the bus, with `bus_wr` high in clock 4 only.
- R4: The word on `bus_din` at the end of clock 2 is driven on `bus_dout` with `bus_doe`=1 in clocks 3 and 4.
- R5: In single mode (`cfg_mode`=1) a bus cycle begins only in the clock after `dreq` is seen high while waiting. The cycle is two clocks long, and `dack` equals `bus_as` in both clocks.
- R6: Single mode with `cfg_dir`=0 (memory to device) puts the source address on the bus with `bus_rd` high in the second clock, and `bus_doe` stays 0.
- R7: Single mode with `cfg_dir`=1 (device to memory) puts the destination address on the bus with `bus_wr` high in the second clock. `bus_doe` stays 0, so the data pins are released.
- R8: A single-mode start whose memory address is at or above `INT_BASE` is refused: `busy` stays 0, no bus cycle runs and `err` becomes 1. The next accepted start clears `err`.
- R9: After each word, an address whose step enable was set at start grows by 2. An address without its step enable stays fixed.
- R10: The count falls by one per word. After the last word, `busy` is 0 and `done` is 1 for exactly one clock.
- R11: `bus_rd` and `bus_wr` are never high together, and neither is high without `bus_as`.
- R12: A start pulse while busy is ignored, and the running job keeps its own addresses and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| cfg_start | input | 1 | start pulse |
| cfg_mode | input | 1 | 0 dual address, 1 single address |
| cfg_dir | input | 1 | single mode: 0 memory read, 1 memory write |
| cfg_src_addr | input | 24 | source address |
| cfg_dst_addr | input | 24 | destination address |
| cfg_src_inc | input | 1 | source step enable |
| cfg_dst_inc | input | 1 | destination step enable |
| cfg_count | input | 16 | words to move |
| busy | output | 1 | job running |
| done | output | 1 | one-clock end-of-job pulse |
| err | output | 1 | last start refused (internal target) |
| bus_addr | output | 24 | bus address |
| bus_as | output | 1 | address strobe |
| bus_rd | output | 1 | read strobe |
| bus_wr | output | 1 | write strobe |
| bus_dout | output | 16 | write data |
| bus_doe | output | 1 | write data enable (0 = released) |
| bus_din | input | 16 | read data |
| dreq | input | 1 | device request |
| dack | output | 1 | device acknowledge / strobe |

## Verification
Inputs change and outputs are sampled on the falling edge. A start seen at a rising edge shows `busy` and, in dual mode, the first read address half a clock later. Each following bus phase appears one clock after the one before it. `done` is due in the clock after the final strobe clock, and a refusal shows in `err` in the clock after the start. The bench steps exactly one falling edge per phase and checks each phase in that cycle, never earlier or later.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_RDA, S_RDS, S_WRA, S_WRS, S_SGA, S_SGS
  } seq_state_t;
  localparam int unsigned N_PTR   = 2;
  localparam int unsigned PTR_SRC = 0;
  localparam int unsigned PTR_DST = 1;
endpackage

// File: rtl/dma_addr_ptr.sv
module dma_addr_ptr #(
  parameter int unsigned AW   = 24,
  parameter int unsigned STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          load_inc,
  input  logic          adv,
  output logic [AW-1:0] addr
);
  logic inc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      inc_q <= 1'b0;
    end else if (load) begin
      addr  <= load_addr;
      inc_q <= load_inc;
    end else if (adv && inc_q) begin
      addr  <= addr + AW'(STEP);
    end
  end

  // R9: a pointer without its step enable never moves on a word boundary
  p_fixed_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !inc_q && !load) |=> $stable(addr));
endmodule

// File: rtl/dma_unit_cnt.sv
module dma_unit_cnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - CW'(1);
  end

  assign last = (cnt == CW'(1));

  // R10: a word never completes with nothing left to move
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt != '0));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_chan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_ok,
  input  logic reject,
  input  logic mode_single,
  input  logic dir_wr,
  input  logic dreq,
  input  logic last,
  output logic unit_end,
  output logic sel_dst,
  output logic cap_en,
  output logic bus_as,
  output logic bus_rd,
  output logic bus_wr,
  output logic bus_doe,
  output logic dack,
  output logic busy,
  output logic done,
  output logic err
);
  seq_state_t st, st_nx;
  logic single_q, wr_q;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (start_ok) st_nx = mode_single ? S_WAIT : S_RDA;
      S_WAIT:  if (dreq) st_nx = S_SGA;
      S_RDA:   st_nx = S_RDS;
      S_RDS:   st_nx = S_WRA;
      S_WRA:   st_nx = S_WRS;
      S_WRS:   st_nx = last ? S_IDLE : S_RDA;
      S_SGA:   st_nx = S_SGS;
      S_SGS:   st_nx = last ? S_IDLE : S_WAIT;
      default: st_nx = S_IDLE;
    endcase
  end

  assign unit_end = (st == S_WRS) || (st == S_SGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      single_q <= 1'b0;
      wr_q     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      st   <= st_nx;
      done <= unit_end && last;
      if (start_ok) begin
        single_q <= mode_single;
        wr_q     <= dir_wr;
        err      <= 1'b0;
      end else if (reject) begin
        err <= 1'b1;
      end
    end
  end

  logic sg;
  assign sg      = (st == S_SGA) || (st == S_SGS);
  assign busy    = (st != S_IDLE);
  assign bus_as  = busy && (st != S_WAIT);
  assign bus_rd  = (st == S_RDS) || ((st == S_SGS) && !wr_q);
  assign bus_wr  = (st == S_WRS) || ((st == S_SGS) && wr_q);
  assign bus_doe = (st == S_WRA) || (st == S_WRS);
  assign dack    = sg;
  assign sel_dst = bus_doe || (sg && wr_q);
  assign cap_en  = (st == S_RDS);

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  p_strobe_in_as_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> bus_as);
  p_dack_with_as_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (bus_as && single_q));
  p_single_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> !bus_doe);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/dma_addr_chan.sv
module dma_addr_chan
  import dma_chan_pkg::*;
#(
  parameter int unsigned   AW         = 24,
  parameter int unsigned   DW         = 16,
  parameter int unsigned   CW         = 16,
  parameter int unsigned   UNIT_BYTES = DW / 8,
  parameter logic [AW-1:0] INT_BASE   = AW'('hFF0000)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start,
  input  logic          cfg_mode,
  input  logic          cfg_dir,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic          cfg_src_inc,
  input  logic          cfg_dst_inc,
  input  logic [CW-1:0] cfg_count,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] bus_addr,
  output logic          bus_as,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din,
  input  logic          dreq,
  output logic          dack
);
  logic [AW-1:0] ld_addr [N_PTR];
  logic          ld_inc  [N_PTR];
  logic [AW-1:0] ptr     [N_PTR];
  logic          unit_end, sel_dst, cap_en, last;
  logic          go, start_ok, reject, internal;
  logic [DW-1:0] rdata_q;

  assign ld_addr[PTR_SRC] = cfg_src_addr;
  assign ld_addr[PTR_DST] = cfg_dst_addr;
  assign ld_inc[PTR_SRC]  = cfg_src_inc;
  assign ld_inc[PTR_DST]  = cfg_dst_inc;

  // the single-mode memory address is the one the direction selects
  assign internal = (cfg_dir ? cfg_dst_addr : cfg_src_addr) >= INT_BASE;
  assign go       = cfg_start && !busy && (cfg_count != '0);
  assign reject   = go && cfg_mode && internal;
  assign start_ok = go && !reject;

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    dma_addr_ptr #(.AW(AW), .STEP(UNIT_BYTES)) i_ptr (
      .clk(clk), .rst_n(rst_n), .load(start_ok),
      .load_addr(ld_addr[g]), .load_inc(ld_inc[g]),
      .adv(unit_end), .addr(ptr[g])
    );
  end

  dma_unit_cnt #(.CW(CW)) i_cnt (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .load_val(cfg_count),
    .dec(unit_end), .last(last)
  );

  dma_seq i_seq (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .reject(reject),
    .mode_single(cfg_mode), .dir_wr(cfg_dir), .dreq(dreq), .last(last),
    .unit_end(unit_end), .sel_dst(sel_dst), .cap_en(cap_en),
    .bus_as(bus_as), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_doe(bus_doe),
    .dack(dack), .busy(busy), .done(done), .err(err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= bus_din;
  end

  assign bus_addr = sel_dst ? ptr[PTR_DST] : ptr[PTR_SRC];
  assign bus_dout = rdata_q;

  // R8: the acknowledged device cycle never addresses the on-chip region
  p_single_external_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (bus_addr < INT_BASE));
  // R8: a refusal never starts a job
  p_reject_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (!busy && err));
  // R2: an accepted start is visible as busy one clock later
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy);
endmodule

// File: tb/test_dma_addr_chan.sv
`timescale 1ns/1ps
module test_dma_addr_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_start = 1'b0, cfg_mode = 1'b0, cfg_dir = 1'b0;
  logic [23:0] cfg_src_addr = '0, cfg_dst_addr = '0;
  logic        cfg_src_inc = 1'b0, cfg_dst_inc = 1'b0;
  logic [15:0] cfg_count = '0;
  logic        busy, done, err, bus_as, bus_rd, bus_wr, bus_doe, dack;
  logic [23:0] bus_addr;
  logic [15:0] bus_dout, bus_din;
  logic        dreq = 1'b0;
  int          nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  // memory model: the word at an address is a fixed function of it
  assign bus_din = {bus_addr[7:0], ~bus_addr[7:0]};

  dma_addr_chan i_dma_addr_chan (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_mode(cfg_mode),
    .cfg_dir(cfg_dir), .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc), .cfg_count(cfg_count),
    .busy(busy), .done(done), .err(err), .bus_addr(bus_addr), .bus_as(bus_as),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .dreq(dreq), .dack(dack)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] word_at(input logic [23:0] a);
    return {a[7:0], ~a[7:0]};
  endfunction

  function automatic logic [7:0] ctl();
    return {busy, done, err, bus_as, bus_rd, bus_wr, bus_doe, dack};
  endfunction

  task automatic t_reset();
    repeat (3) step();
    chk(ctl() == 8'h00, "R1", ctl(), 8'h00);
    rst_n = 1'b1;
    step();
    chk(ctl() == 8'h00, "R1", ctl(), 8'h00);
  endtask

  task automatic t_dual(input logic [23:0] src, input logic [23:0] dst,
                        input bit si, input bit di, input int cnt, input bit poke);
    cfg_mode = 1'b0; cfg_dir = 1'b0;
    cfg_src_addr = src; cfg_dst_addr = dst;
    cfg_src_inc = si; cfg_dst_inc = di;
    cfg_count = 16'(cnt); cfg_start = 1'b1;
    step();
    cfg_start = 1'b0;
    chk(busy, "R2", busy, 1);
    for (int u = 0; u < cnt; u++) begin
      logic [23:0] s, d;
      s = si ? src + 24'(2 * u) : src;
      d = di ? dst + 24'(2 * u) : dst;
      chk(bus_as && !bus_rd && !bus_wr, "R3", ctl(), 8'h90);
      chk(bus_addr == s, (poke && u > 0) ? "R12" : "R9", bus_addr, s);
      step();
      chk(bus_as && bus_rd && !bus_wr && bus_addr == s, "R3", bus_addr, s);
      step();
      chk(bus_as && bus_doe && !bus_wr && !bus_rd, "R4", ctl(), 8'h92);
      chk(bus_dout == word_at(s), "R4", bus_dout, word_at(s));
      chk(bus_addr == d, "R9", bus_addr, d);
      if (poke && u == 0) begin
        cfg_start = 1'b1; cfg_src_addr = 24'h00ABC0; cfg_count = 16'd9;
      end
      step();
      cfg_start = 1'b0;
      chk(bus_as && bus_wr && !bus_rd && bus_doe, "R3", ctl(), 8'h96);
      chk(bus_dout == word_at(s) && bus_addr == d, "R4", bus_dout, word_at(s));
      step();
    end
    chk(done && !busy, "R10", ctl(), 8'h40);
    step();
    chk(!done && !busy && !bus_as, "R10", ctl(), 8'h00);
  endtask

  task automatic t_single(input bit dir, input logic [23:0] a0, input bit inc,
                          input int cnt);
    cfg_mode = 1'b1; cfg_dir = dir; cfg_count = 16'(cnt);
    if (dir) begin
      cfg_dst_addr = a0; cfg_dst_inc = inc;
      cfg_src_addr = 24'h00FFF0; cfg_src_inc = 1'b1;
    end else begin
      cfg_src_addr = a0; cfg_src_inc = inc;
      cfg_dst_addr = 24'h003000; cfg_dst_inc = 1'b1;
    end
    cfg_start = 1'b1;
    step();
    cfg_start = 1'b0;
    for (int u = 0; u < cnt; u++) begin
      logic [23:0] a;
      a = inc ? a0 + 24'(2 * u) : a0;
      chk(busy && !bus_as && !dack, "R5", ctl(), 8'h80);
      step();
      chk(busy && !bus_as && !dack, "R5", ctl(), 8'h80);
      dreq = 1'b1;
      step();
      dreq = 1'b0;
      chk(bus_as && dack && !bus_rd && !bus_wr && !bus_doe, "R5", ctl(), 8'h91);
      chk(bus_addr == a, dir ? "R7" : "R6", bus_addr, a);
      step();
      chk(bus_as && dack && bus_addr == a, "R5", bus_addr, a);
      if (dir) chk(bus_wr && !bus_rd && !bus_doe, "R7", ctl(), 8'h95);
      else     chk(bus_rd && !bus_wr && !bus_doe, "R6", ctl(), 8'h99);
      step();
    end
    chk(done && !busy && !dack, "R10", ctl(), 8'h40);
    step();
    chk(!done, "R10", done, 0);
  endtask

  task automatic t_reject(input bit dir, input logic [23:0] src,
                          input logic [23:0] dst);
    cfg_mode = 1'b1; cfg_dir = dir; cfg_src_addr = src; cfg_dst_addr = dst;
    cfg_count = 16'd2; cfg_start = 1'b1;
    step();
    cfg_start = 1'b0;
    chk(!busy && err && !bus_as && !dack, "R8", ctl(), 8'h20);
    dreq = 1'b1;
    step();
    dreq = 1'b0;
    chk(!busy && err && !bus_as, "R8", ctl(), 8'h20);
  endtask

  task automatic t_zero_count();
    cfg_mode = 1'b0; cfg_count = 16'd0; cfg_src_addr = 24'h000200;
    cfg_start = 1'b1;
    step();
    cfg_start = 1'b0;
    chk(!busy && !bus_as && !bus_rd, "R2", ctl(), 8'h00);
    step();
    chk(!busy && !bus_as, "R2", ctl(), 8'h00);
  endtask

  initial begin
    t_reset();
    t_dual(24'h001000, 24'h002000, 1'b1, 1'b1, 3, 1'b0);
    t_dual(24'h0010F0, 24'h002100, 1'b0, 1'b1, 2, 1'b1);
    t_zero_count();
    t_single(1'b0, 24'h004000, 1'b1, 2);
    t_single(1'b1, 24'h005010, 1'b0, 2);
    t_reject(1'b0, 24'hFF0000, 24'h000100);
    t_single(1'b0, 24'h006000, 1'b1, 1);
    chk(!err, "R8", err, 0);
    t_reject(1'b1, 24'h000100, 24'hFFFFFE);
    t_dual(24'hFF8000, 24'h000400, 1'b1, 1'b0, 1, 1'b0);
    chk(!err, "R8", err, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule